// File: doc/BRIEF.md
# Disk channel program sequencer

This block runs the channel programs of a disk controller. Software loads a starting word address with an output command. From then on the sequencer works alone: it fetches orders from a word-wide memory port, decodes a 4-bit order code, and carries each order out. An order can start a sector transfer or a seek on an abstract drive port. It can pick a drive unit, record a DMA channel range, write the status word or the order pointer back to memory, pause, raise an interrupt through a vector, jump, or halt. The drive mechanics and the DMA data movement belong to other blocks.

The host side takes four command kinds: control, sense, input and output. Each has a 4-bit function number. The response is combinational: an updated accumulator value and a success flag that the processor uses as its skip or condition result. Outwardly the controller is in one of three states: halted, running or interrupting. Input commands succeed only while it is halted.

Top module: `dsk_chan_seq`

## Requirements
- R1: After reset the controller is halted, the order pointer is 0, no memory request, transfer request or interrupt pulse is active, and the status word is 0x8000.
- R2: Output function 15 loads the order pointer from the accumulator, succeeds, and starts fetching: the next memory read is at the loaded address.
- R3: Input commands succeed only while halted (otherwise the flag is 0 and the accumulator passes through). Function 1 returns the controller identifier, function 9 returns the accumulator ORed with the identifier, and function 15 returns the order pointer. Other input functions fail.
- R4: Each order is read as two words at pointer and pointer+1, and the pointer then advances by 2. The order code is bits 15:12 of the first word: 0 halt, 2 format, 3 seek, 4 unit select, 5 read, 6 write, 7 stall, 9 store status, 11 store pointer, 13 DMA select, 14 interrupt, 15 jump. Format, read and write read a third word, which advances the pointer by one more.
- R5: When bit 11 of the first word is set, the order has no effect. For format, read and write the pointer then passes over the third word too.
- R6: Format, read and write present a request on the drive port with op 0, 1 and 2. The request carries the record size (first word bits 3:0), the track (second word bits 9:0), the record number or count (third word bits 15:8), the head (third word bits 5:0) and the selected unit. It stays valid until the drive returns done.
- R7: Seek presents op 3 with the track from second word bits 9:0. Flag bit 1 carries the restore request (second word bit 15) and flag bit 0 carries the clear request (second word bit 14).
- R8: Unit select decodes second word bits 3:0 as one-hot (0001, 0010, 0100, 1000 are units 0 to 3). Any other pattern, or a unit whose ready input is low, sets the status to 0x8001. A format, read or write with no valid unit, or with an unready unit, issues no request and sets the status to 0x8001.
- R9: DMA select sets the channel count minus one from first word bits 3:0 and the first channel from the second word.
- R10: Store status writes the status word, and store pointer writes the pointer of the next order, to the address in the second word.
- R11: The interrupt order retries itself (pointer moved back by 2) while an interrupt is already pending or interrupts are disabled. Otherwise it pulses the post output for one cycle with the vector from the second word and enters the interrupting state. Sense function 4 succeeds only when the controller is not interrupting. Control function 14 returns it to running.
- R12: Stall issues no memory request for STALL_CYCLES+1 cycles after the stall order's last fetch: one decode cycle plus the stall.
- R13: Jump sets the pointer to the second word. Halt, and the undefined codes 1, 8, 10 and 12, stop the controller with the pointer past the order.
- R14: Control function 15 from any state halts the controller, deselects the unit and sets the status to 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Host command present this cycle |
| cmd_kind | input | 2 | 0 control, 1 sense, 2 input, 3 output |
| cmd_func | input | 4 | Function number |
| cmd_acc | input | 16 | Accumulator value from the processor |
| rsp_acc | output | 16 | Accumulator value returned |
| rsp_ok | output | 1 | Command succeeded (skip/condition) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| unit_ready | input | 4 | Per-unit ready |
| xfer_valid | output | 1 | Drive request, held until xfer_done |
| xfer_op | output | 2 | 0 format, 1 read, 2 write, 3 seek |
| xfer_unit | output | 2 | Selected unit |
| xfer_track | output | 10 | Track |
| xfer_head | output | 6 | Head |
| xfer_rec | output | 8 | Record number or count |
| xfer_rsize | output | 4 | Record size code |
| xfer_flags | output | 2 | Seek restore (bit 1) and clear (bit 0) |
| xfer_done | input | 1 | Drive request finished |
| dma_first | output | 16 | First DMA channel |
| dma_count | output | 4 | DMA channel count minus one |
| irq_enable | input | 1 | Processor accepts interrupts |
| irq_pending | input | 1 | An interrupt is already pending |
| irq_post | output | 1 | One-cycle interrupt post |
| irq_vector | output | 16 | Vector address for the posted interrupt |

## Verification
A wrong internal pointer shows up within one fetch as a memory read at an unexpected address, and later as a wrong value stored by the store-pointer order or returned by input function 15. A decode fault shows up as a missing or extra drive request, or as a wrong field on it, as soon as the order runs. A state fault shows up at once at the sense and input responses, which are combinational from the state. A status fault only becomes visible when a store status order runs, so programs place that order straight after the unit choices they test. A stall or interrupt retry fault shows up as the wrong count of idle cycles before the next fetch, or as a post that comes too early.

// File: rtl/dsk_chan_pkg.sv
// Shared types and constants for the disk channel program sequencer.
// Assumes 16-bit words; order field positions are fixed within the word.
package dsk_chan_pkg;
    localparam int WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [3:0] {
        ST_HALT, ST_RD0, ST_RD1, ST_RD2, ST_EXEC,
        ST_XFER, ST_WR, ST_STALL, ST_INT
    } seq_st_t;

    typedef enum logic [1:0] {
        CK_CTL   = 2'd0,
        CK_SENSE = 2'd1,
        CK_IN    = 2'd2,
        CK_OUT   = 2'd3
    } cmd_kind_t;

    localparam logic [3:0] OP_HALT  = 4'd0;
    localparam logic [3:0] OP_FMT   = 4'd2;
    localparam logic [3:0] OP_SEEK  = 4'd3;
    localparam logic [3:0] OP_SEL   = 4'd4;
    localparam logic [3:0] OP_RD    = 4'd5;
    localparam logic [3:0] OP_WR    = 4'd6;
    localparam logic [3:0] OP_STALL = 4'd7;
    localparam logic [3:0] OP_STAT  = 4'd9;
    localparam logic [3:0] OP_SPTR  = 4'd11;
    localparam logic [3:0] OP_DMA   = 4'd13;
    localparam logic [3:0] OP_INT   = 4'd14;
    localparam logic [3:0] OP_JMP   = 4'd15;

    localparam word_t STATUS_IDLE = 16'h8000;
    localparam word_t STATUS_NRDY = 16'h8001;

    // Orders that carry a third word.
    function automatic logic has_third(input logic [3:0] op);
        return (op == OP_FMT) || (op == OP_RD) || (op == OP_WR);
    endfunction

    // One-hot unit field to {valid, index}.
    function automatic logic [2:0] unit_decode(input logic [3:0] f);
        case (f)
            4'b0001: return 3'b100;
            4'b0010: return 3'b101;
            4'b0100: return 3'b110;
            4'b1000: return 3'b111;
            default: return 3'b000;
        endcase
    endfunction
endpackage

// File: rtl/dsk_stall_timer.sv
// Stall timer: while run is high it counts cycles and raises expired in the
// STALL_CYCLES-th cycle. Assumes run drops the cycle after expired.
module dsk_stall_timer #(
    parameter int STALL_CYCLES = 26250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(STALL_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Count while running, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == CW'(STALL_CYCLES - 1));
endmodule

// File: rtl/dsk_host_port.sv
// Host command decoder: turns control/sense/input/output commands into a
// combinational response and one-cycle action strobes for the engine.
// Assumes a command is presented for exactly one cycle.
module dsk_host_port
    import dsk_chan_pkg::*;
#(
    parameter logic [15:0] CTRL_ID = 16'h0016
) (
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_kind,
    input  logic [3:0]  cmd_func,
    input  word_t       cmd_acc,
    input  logic        halted,
    input  logic        interrupting,
    input  word_t       oar,
    output word_t       rsp_acc,
    output logic        rsp_ok,
    output logic        do_load,
    output logic        do_reset,
    output logic        do_resume
);
    // Decode the command into a response and strobes.
    always_comb begin
        rsp_acc   = cmd_acc;
        rsp_ok    = 1'b0;
        do_load   = 1'b0;
        do_reset  = 1'b0;
        do_resume = 1'b0;
        if (cmd_valid) begin
            case (cmd_kind_t'(cmd_kind))
                CK_CTL: begin
                    do_reset  = (cmd_func == 4'd15);
                    do_resume = (cmd_func == 4'd14);
                end
                CK_SENSE: begin
                    if (cmd_func == 4'd4) rsp_ok = !interrupting;
                end
                CK_IN: begin
                    if (halted) begin
                        case (cmd_func)
                            4'd1:  begin rsp_acc = CTRL_ID;           rsp_ok = 1'b1; end
                            4'd9:  begin rsp_acc = cmd_acc | CTRL_ID; rsp_ok = 1'b1; end
                            4'd15: begin rsp_acc = oar;               rsp_ok = 1'b1; end
                            default: ;
                        endcase
                    end
                end
                CK_OUT: begin
                    if (cmd_func == 4'd15) begin
                        do_load = 1'b1;
                        rsp_ok  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dsk_order_engine.sv
// Order engine: fetches orders at the order pointer, decodes and executes
// them, and drives the memory and drive ports. Assumes memory and drive
// responders hold nothing once the request they answer is gone.
module dsk_order_engine
    import dsk_chan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        do_load,
    input  logic        do_reset,
    input  logic        do_resume,
    input  word_t       load_val,
    output logic        mem_req,
    output logic        mem_we,
    output word_t       mem_addr,
    output word_t       mem_wdata,
    input  word_t       mem_rdata,
    input  logic        mem_ack,
    input  logic [3:0]  unit_ready,
    output logic        xfer_valid,
    output logic [1:0]  xfer_op,
    output logic [1:0]  xfer_unit,
    output logic [9:0]  xfer_track,
    output logic [5:0]  xfer_head,
    output logic [7:0]  xfer_rec,
    output logic [3:0]  xfer_rsize,
    output logic [1:0]  xfer_flags,
    input  logic        xfer_done,
    output word_t       dma_first,
    output logic [3:0]  dma_count,
    input  logic        irq_enable,
    input  logic        irq_pending,
    output logic        irq_post,
    output word_t       irq_vector,
    output logic        stall_run,
    input  logic        stall_done,
    output logic        halted,
    output logic        interrupting,
    output word_t       oar
);
    seq_st_t     st;
    word_t       w0, w1, w2, status, wr_data;
    logic [1:0]  unit;
    logic        unit_ok;
    logic [2:0]  sel_dec;
    logic [3:0]  op;

    assign op      = w0[15:12];
    assign sel_dec = unit_decode(w1[3:0]);

    // Sequencer state, pointer and order registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_HALT; oar <= '0; w0 <= '0; w1 <= '0; w2 <= '0;
            status <= STATUS_IDLE; wr_data <= '0; unit <= '0; unit_ok <= 1'b0;
            dma_first <= '0; dma_count <= '0; irq_post <= 1'b0; irq_vector <= '0;
        end else if (do_reset) begin
            st <= ST_HALT; status <= STATUS_IDLE; unit_ok <= 1'b0; irq_post <= 1'b0;
        end else if (do_load) begin
            oar <= load_val; st <= ST_RD0; irq_post <= 1'b0;
        end else begin
            irq_post <= 1'b0;
            case (st)
                ST_RD0: if (mem_ack) begin w0 <= mem_rdata; st <= ST_RD1; end
                ST_RD1: if (mem_ack) begin
                    w1 <= mem_rdata;
                    if (w0[11]) begin
                        oar <= oar + (has_third(op) ? 16'd3 : 16'd2);
                        st  <= ST_RD0;
                    end else begin
                        oar <= oar + 16'd2;
                        st  <= has_third(op) ? ST_RD2 : ST_EXEC;
                    end
                end
                ST_RD2: if (mem_ack) begin w2 <= mem_rdata; oar <= oar + 16'd1; st <= ST_EXEC; end
                ST_EXEC: begin
                    st <= ST_RD0;
                    case (op)
                        OP_FMT, OP_RD, OP_WR: begin
                            if (unit_ok && unit_ready[unit]) st <= ST_XFER;
                            else                             status <= STATUS_NRDY;
                        end
                        OP_SEEK:  st <= ST_XFER;
                        OP_SEL: begin
                            unit_ok <= sel_dec[2];
                            unit    <= sel_dec[1:0];
                            if (!sel_dec[2] || !unit_ready[sel_dec[1:0]]) status <= STATUS_NRDY;
                        end
                        OP_STALL: st <= ST_STALL;
                        OP_STAT:  begin wr_data <= status; st <= ST_WR; end
                        OP_SPTR:  begin wr_data <= oar;    st <= ST_WR; end
                        OP_DMA:   begin dma_count <= w0[3:0]; dma_first <= w1; end
                        OP_INT: begin
                            if (irq_pending || !irq_enable) oar <= oar - 16'd2;
                            else begin
                                irq_post <= 1'b1; irq_vector <= w1; st <= ST_INT;
                            end
                        end
                        OP_JMP:   oar <= w1;
                        default:  st <= ST_HALT;
                    endcase
                end
                ST_XFER:  if (xfer_done)  st <= ST_RD0;
                ST_WR:    if (mem_ack)    st <= ST_RD0;
                ST_STALL: if (stall_done) st <= ST_RD0;
                ST_INT:   if (do_resume)  st <= ST_RD0;
                default: ;
            endcase
        end
    end

    // Memory port: address and direction from the current state.
    always_comb begin
        mem_req   = (st == ST_RD0) || (st == ST_RD1) || (st == ST_RD2) || (st == ST_WR);
        mem_we    = (st == ST_WR);
        mem_wdata = wr_data;
        case (st)
            ST_RD1:  mem_addr = oar + 16'd1;
            ST_WR:   mem_addr = w1;
            default: mem_addr = oar;
        endcase
    end

    // Drive port fields from the held order words.
    always_comb begin
        case (op)
            OP_FMT:  xfer_op = 2'd0;
            OP_RD:   xfer_op = 2'd1;
            OP_WR:   xfer_op = 2'd2;
            default: xfer_op = 2'd3;
        endcase
    end
    assign xfer_valid   = (st == ST_XFER);
    assign xfer_unit    = unit;
    assign xfer_track   = w1[9:0];
    assign xfer_flags   = w1[15:14];
    assign xfer_head    = w2[5:0];
    assign xfer_rec     = w2[15:8];
    assign xfer_rsize   = w0[3:0];
    assign stall_run    = (st == ST_STALL);
    assign halted       = (st == ST_HALT);
    assign interrupting = (st == ST_INT);

    // R4: an unanswered memory access keeps its address.
    assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !do_load && !do_reset) |=> (mem_req && $stable(mem_addr)));
    // R6: a drive request is held until done.
    assert_xfer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_done && !do_load && !do_reset) |=> xfer_valid);
    // R11: the post lasts one cycle and the engine is quiet while posting.
    assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_post |=> !irq_post);
    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_post |-> (!mem_req && !xfer_valid));
    // R13: a halted controller makes no requests.
    assert_halt_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_req && !xfer_valid && !irq_post));
endmodule

// File: rtl/dsk_chan_seq.sv
// Disk channel program sequencer top: host command port, order engine and
// stall timer. Assumes single-cycle host commands and handshaked memory.
module dsk_chan_seq
    import dsk_chan_pkg::*;
#(
    parameter int          STALL_CYCLES = 26250,
    parameter logic [15:0] CTRL_ID      = 16'h0016
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_kind,
    input  logic [3:0]  cmd_func,
    input  logic [15:0] cmd_acc,
    output logic [15:0] rsp_acc,
    output logic        rsp_ok,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    input  logic        mem_ack,
    input  logic [3:0]  unit_ready,
    output logic        xfer_valid,
    output logic [1:0]  xfer_op,
    output logic [1:0]  xfer_unit,
    output logic [9:0]  xfer_track,
    output logic [5:0]  xfer_head,
    output logic [7:0]  xfer_rec,
    output logic [3:0]  xfer_rsize,
    output logic [1:0]  xfer_flags,
    input  logic        xfer_done,
    output logic [15:0] dma_first,
    output logic [3:0]  dma_count,
    input  logic        irq_enable,
    input  logic        irq_pending,
    output logic        irq_post,
    output logic [15:0] irq_vector
);
    logic  do_load, do_reset, do_resume, halted, interrupting;
    logic  stall_run, stall_done;
    word_t oar;

    dsk_host_port #(.CTRL_ID(CTRL_ID)) u_host (
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_func(cmd_func),
        .cmd_acc(cmd_acc), .halted(halted), .interrupting(interrupting),
        .oar(oar), .rsp_acc(rsp_acc), .rsp_ok(rsp_ok), .do_load(do_load),
        .do_reset(do_reset), .do_resume(do_resume)
    );

    dsk_order_engine u_eng (
        .clk(clk), .rst_n(rst_n), .do_load(do_load), .do_reset(do_reset),
        .do_resume(do_resume), .load_val(cmd_acc), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .unit_ready(unit_ready),
        .xfer_valid(xfer_valid), .xfer_op(xfer_op), .xfer_unit(xfer_unit),
        .xfer_track(xfer_track), .xfer_head(xfer_head), .xfer_rec(xfer_rec),
        .xfer_rsize(xfer_rsize), .xfer_flags(xfer_flags), .xfer_done(xfer_done),
        .dma_first(dma_first), .dma_count(dma_count), .irq_enable(irq_enable),
        .irq_pending(irq_pending), .irq_post(irq_post), .irq_vector(irq_vector),
        .stall_run(stall_run), .stall_done(stall_done), .halted(halted),
        .interrupting(interrupting), .oar(oar)
    );

    dsk_stall_timer #(.STALL_CYCLES(STALL_CYCLES)) u_stall (
        .clk(clk), .rst_n(rst_n), .run(stall_run), .expired(stall_done)
    );
endmodule

// File: tb/dsk_chan_seq_bench.sv
module dsk_chan_seq_bench;
    localparam int STALL = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = '0;
    logic [3:0]  cmd_func = '0;
    logic [15:0] cmd_acc = '0;
    logic [15:0] rsp_acc;
    logic        rsp_ok;
    logic        mem_req, mem_we, mem_ack;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  unit_ready = 4'b1111;
    logic        xfer_valid, xfer_done;
    logic [1:0]  xfer_op, xfer_unit, xfer_flags;
    logic [9:0]  xfer_track;
    logic [5:0]  xfer_head;
    logic [7:0]  xfer_rec;
    logic [3:0]  xfer_rsize, dma_count;
    logic [15:0] dma_first, irq_vector;
    logic        irq_enable = 1'b0, irq_pending = 1'b0, irq_post;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    dsk_chan_seq #(.STALL_CYCLES(STALL)) u_dsk_chan_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_func(cmd_func), .cmd_acc(cmd_acc), .rsp_acc(rsp_acc), .rsp_ok(rsp_ok),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .unit_ready(unit_ready), .xfer_valid(xfer_valid), .xfer_op(xfer_op),
        .xfer_unit(xfer_unit), .xfer_track(xfer_track), .xfer_head(xfer_head),
        .xfer_rec(xfer_rec), .xfer_rsize(xfer_rsize), .xfer_flags(xfer_flags),
        .xfer_done(xfer_done), .dma_first(dma_first), .dma_count(dma_count),
        .irq_enable(irq_enable), .irq_pending(irq_pending), .irq_post(irq_post),
        .irq_vector(irq_vector)
    );

    // Memory model: one-cycle answer to each request.
    logic [15:0] mem [0:255];
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= mem[mem_addr[7:0]];
                if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            end
        end
    end

    // Drive model: done one cycle after a request appears.
    always @(posedge clk) begin
        if (!rst_n) xfer_done <= 1'b0;
        else        xfer_done <= xfer_valid && !xfer_done;
    end

    // Monitors sampled at the falling edge.
    int n_xfer = 0, n_write_op = 0, n_irq = 0, gap = 0, gap_rec = -1;
    logic [15:0] last_rd = '0, got_vec = '0, first_rd = '0;
    logic        first_seen = 1'b0;
    logic [31:0] rd_fields = '0, sk_fields = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (xfer_valid && xfer_done) begin
                n_xfer++;
                if (xfer_op == 2'd2) n_write_op++;
                if (xfer_op == 2'd1)
                    rd_fields = {2'b0, xfer_unit, xfer_track, xfer_head, xfer_rec, xfer_rsize};
                if (xfer_op == 2'd3) sk_fields = {20'b0, xfer_flags, xfer_track};
            end
            if (irq_post) begin n_irq++; got_vec = irq_vector; end
            if (mem_req && !mem_we) begin
                last_rd = mem_addr;
                if (!first_seen) begin first_rd = mem_addr; first_seen = 1'b1; end
            end
            if (mem_req && !mem_we && mem_addr == 16'h0031) gap = 0;
            else if (!mem_req) gap++;
            if (mem_req && mem_addr == 16'h0032 && gap_rec < 0) gap_rec = gap;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host(input logic [1:0] k, input logic [3:0] f, input logic [15:0] a,
                        output logic ok, output logic [15:0] r);
        @(negedge clk);
        cmd_kind = k; cmd_func = f; cmd_acc = a; cmd_valid = 1'b1;
        #1; ok = rsp_ok; r = rsp_acc;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Host vectors while halted: kind, func, acc, expected ok, expected acc.
    localparam logic [38:0] VEC [0:5] = '{
        {2'd2, 4'd1,  16'hFF00, 1'b1, 16'h0016},  // R3 identifier
        {2'd2, 4'd9,  16'hFF00, 1'b1, 16'hFF16},  // R3 OR identifier
        {2'd2, 4'd15, 16'h1234, 1'b1, 16'h0000},  // R1 R3 pointer is 0
        {2'd1, 4'd4,  16'h0000, 1'b1, 16'h0000},  // R11 not interrupting
        {2'd2, 4'd3,  16'h5555, 1'b0, 16'h5555},  // R3 unknown input fails
        {2'd0, 4'd0,  16'h0000, 1'b0, 16'h0000}   // R14 other control no skip
    };

    initial begin
        logic ok;
        logic [15:0] r;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        // Program A
        mem[8'h10] = 16'h4000; mem[8'h11] = 16'h0004;
        mem[8'h12] = 16'h5003; mem[8'h13] = 16'h0123; mem[8'h14] = 16'h0705;
        mem[8'h15] = 16'h3000; mem[8'h16] = 16'hC045;
        mem[8'h17] = 16'hD002; mem[8'h18] = 16'h0040;
        mem[8'h19] = 16'h6800; mem[8'h1A] = 16'h0000; mem[8'h1B] = 16'h0000;
        mem[8'h1C] = 16'h9000; mem[8'h1D] = 16'h0080;
        mem[8'h1E] = 16'hB000; mem[8'h1F] = 16'h0081;
        mem[8'h20] = 16'hF000; mem[8'h21] = 16'h0030;
        mem[8'h30] = 16'h7000; mem[8'h31] = 16'h0000;
        mem[8'h32] = 16'hE000; mem[8'h33] = 16'h0155;
        // Program B
        mem[8'h40] = 16'h4000; mem[8'h41] = 16'h0004;
        mem[8'h42] = 16'h5000; mem[8'h43] = 16'h0001; mem[8'h44] = 16'h0100;
        mem[8'h45] = 16'h9000; mem[8'h46] = 16'h0082;
        mem[8'h47] = 16'h8000;
        // Program C
        mem[8'h50] = 16'h9000; mem[8'h51] = 16'h0083;
        mem[8'h52] = 16'h2000; mem[8'h53] = 16'h0001; mem[8'h54] = 16'h0000;
        mem[8'h55] = 16'h9000; mem[8'h56] = 16'h0084;
        // Program D: endless jump
        mem[8'h60] = 16'hF000; mem[8'h61] = 16'h0060;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mem_req idle", 32'(mem_req), 32'd0);
        chk("R1 xfer idle", 32'(xfer_valid), 32'd0);
        chk("R1 irq idle", 32'(irq_post), 32'd0);

        foreach (VEC[i]) begin
            host(VEC[i][38:37], VEC[i][36:33], VEC[i][32:17], ok, r);
            chk($sformatf("vector %0d ok", i), 32'(ok), 32'(VEC[i][16]));
            chk($sformatf("vector %0d acc", i), 32'(r), 32'(VEC[i][15:0]));
        end

        // Program A, interrupts disabled
        host(2'd3, 4'd15, 16'h0010, ok, r);
        chk("R2 load ok", 32'(ok), 32'd1);
        repeat (300) @(negedge clk);
        chk("R2 first fetch address", 32'(first_rd), 32'h10);
        chk("R6 read fields", rd_fields, {2'b0, 2'd2, 10'h123, 6'd5, 8'd7, 4'd3});
        chk("R7 seek fields", sk_fields, {20'b0, 2'b11, 10'h045});
        chk("R5 skipped write issues nothing", 32'(n_write_op), 32'd0);
        chk("R5 two drive requests", 32'(n_xfer), 32'd2);
        chk("R9 dma first", 32'(dma_first), 32'h40);
        chk("R9 dma count", 32'(dma_count), 32'd2);
        chk("R10 stored status", 32'(mem[8'h80]), 32'h8000);
        chk("R4 R10 stored pointer", 32'(mem[8'h81]), 32'h0020);
        chk("R12 stall idle cycles", 32'(gap_rec), 32'(STALL + 1));
        chk("R11 no post while disabled", 32'(n_irq), 32'd0);
        chk("R11 retry refetches order", 32'(last_rd == 16'h32 || last_rd == 16'h33), 32'd1);
        host(2'd2, 4'd1, 16'h0000, ok, r);
        chk("R3 input rejected while running", 32'(ok), 32'd0);
        irq_enable = 1'b1; irq_pending = 1'b1;
        repeat (50) @(negedge clk);
        chk("R11 no post while pending", 32'(n_irq), 32'd0);
        irq_pending = 1'b0;
        repeat (30) @(negedge clk);
        chk("R11 one post", 32'(n_irq), 32'd1);
        chk("R11 vector", 32'(got_vec), 32'h155);
        host(2'd1, 4'd4, 16'h0000, ok, r);
        chk("R11 sense while interrupting", 32'(ok), 32'd0);
        host(2'd2, 4'd15, 16'h0000, ok, r);
        chk("R3 input rejected while interrupting", 32'(ok), 32'd0);
        host(2'd0, 4'd14, 16'h0000, ok, r);
        repeat (30) @(negedge clk);
        host(2'd2, 4'd15, 16'h0000, ok, r);
        chk("R13 halted after halt order", 32'(ok), 32'd1);
        chk("R13 pointer past halt", 32'(r), 32'h0036);
        host(2'd1, 4'd4, 16'h0000, ok, r);
        chk("R11 sense after resume", 32'(ok), 32'd1);

        // Program B: unready unit, undefined code
        unit_ready = 4'b1011;
        host(2'd3, 4'd15, 16'h0040, ok, r);
        repeat (80) @(negedge clk);
        chk("R8 no request to unready unit", 32'(n_xfer), 32'd2);
        chk("R8 not-ready status", 32'(mem[8'h82]), 32'h8001);
        host(2'd2, 4'd15, 16'h0000, ok, r);
        chk("R13 undefined code halts", 32'(ok), 32'd1);
        chk("R13 pointer past undefined", 32'(r), 32'h0049);

        // Control reset, then Program C
        host(2'd0, 4'd15, 16'h0000, ok, r);
        host(2'd3, 4'd15, 16'h0050, ok, r);
        repeat (80) @(negedge clk);
        chk("R14 status after control reset", 32'(mem[8'h83]), 32'h8000);
        chk("R8 R14 no unit after reset", 32'(mem[8'h84]), 32'h8001);
        chk("R8 no request without unit", 32'(n_xfer), 32'd2);

        // Program D: reset while running
        host(2'd3, 4'd15, 16'h0060, ok, r);
        repeat (20) @(negedge clk);
        host(2'd2, 4'd1, 16'h0000, ok, r);
        chk("R13 jump loop keeps running", 32'(ok), 32'd0);
        host(2'd0, 4'd15, 16'h0000, ok, r);
        host(2'd2, 4'd1, 16'h0000, ok, r);
        chk("R14 halted by control reset", 32'(ok), 32'd1);
        repeat (2) @(negedge clk);
        chk("R14 memory quiet after reset", 32'(mem_req), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule